// File: doc/BRIEF.md
# Programmable Watchdog With Expiry Steering

A watchdog timer run from a single 8-bit control register. The register holds a multiplier and a power-of-four resolution. Together they set the timeout, counted in ticks of a 16 Hz enable. When the count runs out, the top bit of the register decides the outcome. It either produces a one-cycle interrupt pulse, or it produces a one-cycle system reset request and wipes the control register. Either way, a sticky expiry flag becomes visible in a read-only flags register.

Software services the watchdog by accessing the control register. Any write loads a new setting and starts a fresh countdown. A read strobe on the control register restarts the countdown with the stored setting. Both kinds of restart clear the expiry flag. A third register holds a century bit, which a reset-steered expiry clears. After any expiry the timer idles until software restarts it.

Top module: `wdog_steer`

## Requirements
- R1: After reset, all three outputs are low, the control register reads 8'h00, the flags register reads 8'h00 and the century register reads 8'h00.
- R2: With control value V, the resolution field R is V[1:0] and the multiplier M is V[6:2]. The timeout N is M*4^R ticks. For N>=1, expiry happens on exactly the N-th tick after the restart and on no earlier tick.
- R3: A control value of 8'h00 disables the watchdog. No pulse and no flag appear, however many ticks arrive.
- R4: A control write during a countdown discards the old count and restarts the countdown from the newly written value.
- R5: A rd_en strobe with reg_sel=0 restarts the countdown from the stored value and leaves that value unchanged.
- R6: Any restart, whether a write or a read strobe on reg_sel=0, clears the expiry flag. The flag appears as bit 7 of the flags register (reg_sel=1) and on wd_flag.
- R7: Expiry sets the flag. The flag stays set through further ticks until a restart.
- R8: On expiry with V[7]=1, rst_req pulses high for exactly one cycle and irq_pulse stays low. The control register becomes 8'h00, and bit 6 of the century register (reg_sel=2) is cleared.
- R9: On expiry with V[7]=0, irq_pulse pulses high for exactly one cycle and rst_req stays low. The control register keeps its value.
- R10: With M=0 and R!=0 (nonzero register, zero timeout), expiry happens on the first tick after the restart.
- R11: After an expiry the block is idle. No further pulse appears on later ticks until a restart.
- R12: The century register stores only wr_data[6] and reads as {1'b0, bit, 6'b0}. Writes to the flags register (reg_sel=1) are ignored. rd_data shows the selected register combinationally, with no strobe needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle enable, 16 per second |
| reg_sel | input | 2 | 0 control, 1 flags, 2 century |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (restarts on reg_sel=0) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register contents |
| irq_pulse | output | 1 | One-cycle interrupt on expiry |
| rst_req | output | 1 | One-cycle reset request on expiry |
| wd_flag | output | 1 | Sticky expiry flag |

## Verification
The hardest case to reach is the largest timeout: multiplier 31 at the coarsest resolution, which needs 1984 ticks before anything is visible. The stimulus table walks it tick by tick. Each tick is checked for an early pulse, so an off-by-one at either end of the count shows up.

A restart that lands partway through a count also needs precise sequencing. The bench interleaves mid-count writes and read strobes with counted ticks, so the old and new deadlines fall on different ticks.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int DW    = 8,
  parameter int RES_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_16hz,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq_pulse,
  output logic          rst_req,
  output logic          wd_flag
);
  localparam int MULT_W = DW - 1 - RES_W;
  localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [DW-1:0]    ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, century_q;

  wire ctrl_wr = wr_en && (reg_sel == 2'd0);
  wire ctrl_rd = rd_en && !wr_en && (reg_sel == 2'd0);
  wire restart = ctrl_wr || ctrl_rd;

  wire [DW-1:0]     new_val = ctrl_wr ? wr_data : ctrl_q;
  wire [RES_W-1:0]  res     = new_val[RES_W-1:0];
  wire [MULT_W-1:0] mult    = new_val[DW-2:RES_W];
  wire [CNT_W-1:0]  load    = CNT_W'(mult) << {res, 1'b0};

  wire expire = active_q && tick_16hz && !restart && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      century_q <= 1'b0;
      wd_flag   <= 1'b0;
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
      if (wr_en && reg_sel == 2'd2) century_q <= wr_data[DW-2];
      if (restart) begin
        ctrl_q   <= new_val;
        cnt_q    <= load;
        active_q <= (new_val != '0);
        wd_flag  <= 1'b0;
      end else if (expire) begin
        wd_flag  <= 1'b1;
        active_q <= 1'b0;
        if (ctrl_q[DW-1]) begin
          rst_req   <= 1'b1;
          ctrl_q    <= '0;
          century_q <= 1'b0;
        end else begin
          irq_pulse <= 1'b1;
        end
      end else if (active_q && tick_16hz) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    rd_data = ctrl_q;
      2'd1:    rd_data = {wd_flag, {(DW-1){1'b0}}};
      2'd2:    rd_data = {1'b0, century_q, {(DW-2){1'b0}}};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_pulse,
  input logic          rst_req,
  input logic          wd_flag,
  input logic          active_q,
  input logic          wr_en,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] ctrl_q
);
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && rst_req));
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_rst_wipes_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctrl_q == '0));
  p_flag_on_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || rst_req) |-> wd_flag);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !(irq_pulse || rst_req));
  p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0) |=> !wd_flag);
endmodule

bind wdog_steer wdog_steer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .rst_req(rst_req),
  .wd_flag(wd_flag), .active_q(active_q), .wr_en(wr_en),
  .reg_sel(reg_sel), .ctrl_q(ctrl_q)
);

// File: tb/tb_wdog_steer.sv
module tb_wdog_steer;
  logic       clk = 1'b0, rst_n = 1'b0, tick_16hz = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_pulse, rst_req, wd_flag;
  int checks = 0, errors = 0;
  logic seen_irq, seen_rst;

  always #10 clk = ~clk;

  wdog_steer dut (.clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .reg_sel(reg_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_pulse(irq_pulse), .rst_req(rst_req), .wd_flag(wd_flag));

  localparam int NV = 8;
  localparam logic [7:0] VEC_VAL [0:NV-1] = '{8'h05, 8'h0A, 8'h07, 8'h7C, 8'h7F, 8'h01, 8'h84, 8'h8E};
  localparam int         VEC_N   [0:NV-1] = '{4, 32, 64, 31, 1984, 1, 1, 48};
  localparam bit         VEC_RST [0:NV-1] = '{0, 0, 0, 0, 0, 0, 1, 1};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_strobe();
    reg_sel = 2'd0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel; #1 v = rd_data;
  endtask

  task automatic tick();
    tick_16hz = 1'b1;
    @(negedge clk); tick_16hz = 1'b0;
    seen_irq = irq_pulse; seen_rst = rst_req;
  endtask

  task automatic ticks_quiet(input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (seen_irq || seen_rst) hits++;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", irq_pulse, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 flag", wd_flag, 0);
    peek(2'd0, v); check("R1 ctrl", v, 8'h00);
    peek(2'd1, v); check("R1 flags reg", v, 8'h00);
    peek(2'd2, v); check("R1 century", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic pi, pr;
      tag = (i == 5) ? "R10" : "R2";
      wr(2'd2, 8'h40);
      wr(2'd0, VEC_VAL[i]);
      check("R6 flag cleared by write", wd_flag, 0);
      ticks_quiet(VEC_N[i] - 1, hits);
      check({tag, " no early expiry"}, hits, 0);
      tick();
      pi = seen_irq; pr = seen_rst;
      check({tag, VEC_RST[i] ? " R8 rst_req at deadline" : " R9 irq at deadline"},
            VEC_RST[i] ? pr : pi, 1);
      check(VEC_RST[i] ? "R8 no irq" : "R9 no rst_req", VEC_RST[i] ? pi : pr, 0);
      @(negedge clk);
      check("R8/R9 single-cycle pulse", {30'd0, irq_pulse, rst_req}, 0);
      peek(2'd1, v); check("R7 flags reg bit7", v, 8'h80);
      peek(2'd0, v); check(VEC_RST[i] ? "R8 ctrl wiped" : "R9 ctrl kept", v,
                           VEC_RST[i] ? 8'h00 : VEC_VAL[i]);
      peek(2'd2, v); check(VEC_RST[i] ? "R8 century cleared" : "R9 century kept", v,
                           VEC_RST[i] ? 8'h00 : 8'h40);
    end

    wr(2'd0, 8'h05);
    ticks_quiet(4, hits);
    check("R9 expiry count", hits, 1);
    ticks_quiet(50, hits);
    check("R11 idle after expiry", hits, 0);
    check("R7 flag sticky", wd_flag, 1);
    wr(2'd1, 8'h00);
    peek(2'd1, v); check("R12 flags write ignored", v, 8'h80);

    wr(2'd0, 8'h00);
    check("R6 flag cleared", wd_flag, 0);
    ticks_quiet(100, hits);
    check("R3 disabled no pulse", hits, 0);
    check("R3 disabled no flag", wd_flag, 0);

    wr(2'd0, 8'h7C);
    ticks_quiet(10, hits);
    wr(2'd0, 8'h05);
    ticks_quiet(3, hits);
    check("R4 no pulse before new deadline", hits, 0);
    tick();
    check("R4 pulse at new deadline", seen_irq, 1);

    wr(2'd0, 8'h05);
    ticks_quiet(3, hits);
    rd_strobe();
    ticks_quiet(3, hits);
    check("R5 read strobe restarts", hits, 0);
    tick();
    check("R5 pulse after read restart", seen_irq, 1);
    peek(2'd0, v); check("R5 value unchanged", v, 8'h05);
    rd_strobe();
    check("R6 read strobe clears flag", wd_flag, 0);

    wr(2'd2, 8'hFF);
    peek(2'd2, v); check("R12 century bit only", v, 8'h40);
    wr(2'd2, 8'hBF);
    peek(2'd2, v); check("R12 century cleared", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule